// File: doc/BRIEF.md
# Four-LFSR summation stream generator

This block generates the key stream of a summation-combiner stream cipher. Four linear feedback shift registers of lengths 25, 31, 33 and 39 hold 128 bits of state between them. A combiner with a two-bit carry memory turns their four output bits into one key stream bit per clock. A start command captures a 128-bit key, a 48-bit device address and a 26-bit clock value into four staging registers. These then feed the shift registers serially while each register's feedback stays disconnected until it has filled.

An 8-bit cycle counter, cleared by each start, sequences the run. The generator first clocks through 240 initialisation cycles. In the next cycle the last 128 generated bits are reloaded in parallel into the four shift registers, and the combiner carry is frozen for that one cycle. After that the key stream is flagged valid and runs on with no limit. Combining the stream with payload data is left to the surrounding logic.

Top module: `sumgen_top`

## Requirements
- R1: After reset, and while no run is active, `ks_o` and `ks_valid_o` are 0.
- R2: On a start the input word V = {6'b0, tick_i, addr_i, key_i} (208 bits, key in V[127:0]) is captured into four staging registers: lane 0 takes V[48:0], lane 1 V[103:49], lane 2 V[152:104] and lane 3 V[207:153]. All shift registers and the carry are cleared. On each counted cycle a staging register delivers its lowest bit into stage 0 of its lane and shifts right, so bit j enters in counted cycle j.
- R3: Lane n (lengths 25, 31, 33, 39) has its feedback forced to 0 while the counter value is below its length. From that count on, the feedback is its top bit.
- R4: Once a staging register is used up, zeros enter its lane behind the data.
- R5: Each lane shifts toward higher indices. Stage 0 takes the input bit XOR the feedback, and the feedback is also XORed into the tap stages: {8,12,20} for lane 0, {12,16,24} for lane 1, {4,24,28} for lane 2 and {4,28,36} for lane 3. The output bit x of a lane is its top stage.
- R6: The key stream bit is z = x0^x1^x2^x3^c[0]. On each step, with S = x0+x1+x2+x3+c and prior carry p, the carry becomes floor(S/2) ^ c ^ {p[0], p[1]^p[0]} and p takes the old c.
- R7: In counted cycle 240, lane 0 loads history bits [24:0], lane 1 [55:25], lane 2 [88:56] and lane 3 [127:89]. History bit 0 is the bit generated in cycle 239 and bit 127 the one from cycle 112. In that cycle the carry and the prior carry hold.
- R8: `ks_valid_o` rises exactly 241 clocks after the start edge and stays high until the next start or init. While it is low, `ks_o` is 0.
- R9: A synchronous `init_i` stops the run, clears all state and has priority over a start in the same cycle.
- R10: A start during a run restarts the sequence from counted cycle 0 with the new inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Synchronous clear of all state |
| start_i | input | 1 | Capture inputs and begin a run |
| key_i | input | 128 | Key word |
| addr_i | input | 48 | Device address |
| tick_i | input | 26 | Clock value input |
| ks_o | output | 1 | Key stream bit |
| ks_valid_o | output | 1 | Key stream bit is valid |

## Verification
The bench goes after the staggered feedback enables. If a lane closed its feedback one count early or late, the whole stream would diverge a few dozen cycles into the run. It also targets the reload cycle: a design that let the carry advance, shifted the lanes or took the history off by one bit would show wrong bits from the first valid cycle on. It checks that valid appears exactly 241 clocks after start, and that a restart or an init in the middle of a run starts the sequence again or stops it cleanly. An init that lost its priority over start would leave a run going.

// File: rtl/sumgen_pkg.sv
package sumgen_pkg;
    localparam int LANES   = 4;
    localparam int KEY_W   = 128;
    localparam int ADDR_W  = 48;
    localparam int TICK_W  = 26;
    localparam int IN_W    = 208;
    localparam int STATE_W = 128;
    localparam int CNT_W   = 8;
    localparam int RELOAD_AT = 240;
    localparam int STREAM_AT = RELOAD_AT + 1;

    localparam int LEN_TBL  [LANES] = '{25, 31, 33, 39};
    localparam int STW_TBL  [LANES] = '{49, 55, 49, 55};
    localparam int SOFF_TBL [LANES] = '{0, 49, 104, 153};
    localparam int ROFF_TBL [LANES] = '{0, 25, 56, 89};
    localparam logic [63:0] TAP_TBL [LANES] = '{
        64'h0000_0000_0010_1100,
        64'h0000_0000_0101_1000,
        64'h0000_0000_1100_0010 | 64'h0000_0000_0000_0010,
        64'h0000_0010_1000_0010 | 64'h0000_0000_0000_0010
    };
endpackage

// File: rtl/sumgen_lane.sv
module sumgen_lane #(
    parameter int          LEN  = 25,
    parameter int          STW  = 49,
    parameter logic [63:0] TAPS = 64'h0
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           clear_i,
    input  logic           load_i,
    input  logic [STW-1:0] stage_val_i,
    input  logic           step_i,
    input  logic           fb_en_i,
    input  logic           reload_i,
    input  logic [LEN-1:0] reload_val_i,
    output logic           msb_o
);
    typedef struct packed {
        logic [LEN-1:0] lf;
        logic [STW-1:0] st;
    } lane_t;

    lane_t cur_q, nxt_d;
    logic  fb;

    always_comb begin
        nxt_d = cur_q;
        fb    = fb_en_i & cur_q.lf[LEN-1];
        if (clear_i) begin
            nxt_d = '0;
        end else if (load_i) begin
            nxt_d.lf = '0;
            nxt_d.st = stage_val_i;
        end else if (reload_i) begin
            nxt_d.lf = reload_val_i;
        end else if (step_i) begin
            nxt_d.lf[0] = cur_q.st[0] ^ fb;
            for (int k = 1; k < LEN; k++) begin
                nxt_d.lf[k] = cur_q.lf[k-1] ^ (TAPS[k] & fb);
            end
            nxt_d.st = {1'b0, cur_q.st[STW-1:1]};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign msb_o = cur_q.lf[LEN-1];

    assert_fill_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !fb_en_i && !clear_i && !load_i && !reload_i)
        |=> (cur_q.lf[0] == $past(cur_q.st[0])));

    assert_zero_pad_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !clear_i && !load_i && !reload_i)
        |=> (cur_q.st[STW-1] == 1'b0));

    assert_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reload_i && !clear_i && !load_i) |=> (cur_q.lf == $past(reload_val_i)));
endmodule

// File: rtl/sumgen_combiner.sv
module sumgen_combiner (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clear_i,
    input  logic       step_i,
    input  logic [3:0] x_i,
    output logic       z_o
);
    typedef struct packed {
        logic [1:0] c;
        logic [1:0] p;
    } carry_t;

    carry_t cur_q, nxt_d;
    logic [2:0] sum;
    logic [1:0] half;
    logic [1:0] mixed;

    always_comb begin
        sum   = 3'(x_i[0]) + 3'(x_i[1]) + 3'(x_i[2]) + 3'(x_i[3]) + {1'b0, cur_q.c};
        half  = sum[2:1];
        mixed = {cur_q.p[0], cur_q.p[1] ^ cur_q.p[0]};
        nxt_d = cur_q;
        if (clear_i) begin
            nxt_d = '0;
        end else if (step_i) begin
            nxt_d.c = half ^ cur_q.c ^ mixed;
            nxt_d.p = cur_q.c;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign z_o = ^x_i ^ cur_q.c[0];

    assert_carry_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !clear_i) |=> ($stable(cur_q.c) && $stable(cur_q.p)));

    assert_prior_carry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !clear_i) |=> (cur_q.p == $past(cur_q.c)));
endmodule

// File: rtl/sumgen_top.sv
module sumgen_top
    import sumgen_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              init_i,
    input  logic              start_i,
    input  logic [KEY_W-1:0]  key_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [TICK_W-1:0] tick_i,
    output logic              ks_o,
    output logic              ks_valid_o
);
    localparam int PAD_W = IN_W - KEY_W - ADDR_W - TICK_W;

    typedef struct packed {
        logic               run;
        logic [CNT_W-1:0]   cnt;
        logic [STATE_W-1:0] hist;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [IN_W-1:0]  vin;
    logic [LANES-1:0] x;
    logic [LANES-1:0] fb_en;
    logic             z;
    logic             load, reload, step, is_reload, is_stream;

    assign vin       = {{PAD_W{1'b0}}, tick_i, addr_i, key_i};
    assign load      = start_i & ~init_i;
    assign is_reload = (ctl_q.cnt == CNT_W'(RELOAD_AT));
    assign is_stream = (ctl_q.cnt == CNT_W'(STREAM_AT));
    assign reload    = ctl_q.run & is_reload;
    assign step      = ctl_q.run & ~is_reload;

    always_comb begin
        ctl_d = ctl_q;
        if (init_i) begin
            ctl_d = '0;
        end else if (start_i) begin
            ctl_d      = '0;
            ctl_d.run  = 1'b1;
        end else if (ctl_q.run) begin
            if (ctl_q.cnt < CNT_W'(RELOAD_AT)) begin
                ctl_d.hist = {ctl_q.hist[STATE_W-2:0], z};
            end
            if (!is_stream) begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign fb_en[g] = (ctl_q.cnt >= CNT_W'(LEN_TBL[g]));
        sumgen_lane #(
            .LEN  (LEN_TBL[g]),
            .STW  (STW_TBL[g]),
            .TAPS (TAP_TBL[g])
        ) u_lane (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .clear_i      (init_i),
            .load_i       (load),
            .stage_val_i  (vin[SOFF_TBL[g] +: STW_TBL[g]]),
            .step_i       (step),
            .fb_en_i      (fb_en[g]),
            .reload_i     (reload),
            .reload_val_i (ctl_q.hist[ROFF_TBL[g] +: LEN_TBL[g]]),
            .msb_o        (x[g])
        );
    end

    sumgen_combiner u_comb (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (init_i | start_i),
        .step_i  (step),
        .x_i     (x),
        .z_o     (z)
    );

    assign ks_valid_o = ctl_q.run & is_stream;
    assign ks_o       = ks_valid_o & z;

    assert_init_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_i |=> (!ks_valid_o && !ks_o));

    assert_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !init_i) |=> (ctl_q.cnt == '0 && ctl_q.run && !ks_valid_o));

    assert_valid_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ks_valid_o && !init_i && !start_i) |=> ks_valid_o);

    assert_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ks_valid_o |-> !ks_o);
endmodule

// File: tb/sumgen_top_test.sv
module sumgen_top_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init = 1'b0;
    logic         start = 1'b0;
    logic [127:0] key = '0;
    logic [47:0]  addr = '0;
    logic [25:0]  tick = '0;
    logic         ks, ks_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sumgen_top uut (
        .clk_i(clk), .rst_ni(rst_n), .init_i(init), .start_i(start),
        .key_i(key), .addr_i(addr), .tick_i(tick),
        .ks_o(ks), .ks_valid_o(ks_valid)
    );

    // behavioural reference
    int LENS [4] = '{25, 31, 33, 39};
    int TP   [4][3] = '{'{8, 12, 20}, '{12, 16, 24}, '{4, 24, 28}, '{4, 28, 36}};
    int SOFF [4] = '{0, 49, 104, 153};
    int SWID [4] = '{49, 55, 49, 55};
    int ROFF [4] = '{0, 25, 56, 89};
    bit m_lf [4][40];
    bit m_st [4][56];
    bit m_h  [128];
    int m_c, m_cp, m_cnt;
    bit m_run;

    function automatic void m_clear();
        for (int i = 0; i < 4; i++) begin
            for (int k = 0; k < 40; k++) m_lf[i][k] = 1'b0;
            for (int k = 0; k < 56; k++) m_st[i][k] = 1'b0;
        end
        for (int k = 0; k < 128; k++) m_h[k] = 1'b0;
        m_c = 0; m_cp = 0; m_cnt = 0; m_run = 1'b0;
    endfunction

    function automatic bit m_z();
        bit r = m_c[0];
        for (int i = 0; i < 4; i++) r ^= m_lf[i][LENS[i]-1];
        return r;
    endfunction

    function automatic void m_step(bit i_init, bit i_start);
        bit [207:0] v;
        bit zb, fb;
        int s;
        if (i_init) begin
            m_clear();
        end else if (i_start) begin
            m_clear();
            v = {6'b0, tick, addr, key};
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < SWID[i]; j++) m_st[i][j] = v[SOFF[i] + j];
            m_run = 1'b1;
        end else if (m_run) begin
            zb = m_z();
            if (m_cnt == 240) begin
                for (int i = 0; i < 4; i++)
                    for (int k = 0; k < LENS[i]; k++) m_lf[i][k] = m_h[ROFF[i] + k];
            end else begin
                s = m_c;
                for (int i = 0; i < 4; i++) s += int'(m_lf[i][LENS[i]-1]);
                for (int i = 0; i < 4; i++) begin
                    fb = (m_cnt >= LENS[i]) && m_lf[i][LENS[i]-1];
                    for (int k = LENS[i]-1; k > 0; k--)
                        m_lf[i][k] = m_lf[i][k-1] ^
                            (fb && (k == TP[i][0] || k == TP[i][1] || k == TP[i][2]));
                    m_lf[i][0] = m_st[i][0] ^ fb;
                    for (int j = 0; j < SWID[i]-1; j++) m_st[i][j] = m_st[i][j+1];
                    m_st[i][SWID[i]-1] = 1'b0;
                end
                begin
                    int t2 = ((m_cp & 1) << 1) | (((m_cp >> 1) ^ m_cp) & 1);
                    int nc = (s / 2) ^ m_c ^ t2;
                    m_cp = m_c;
                    m_c = nc;
                end
                if (m_cnt < 240) begin
                    for (int k = 127; k > 0; k--) m_h[k] = m_h[k-1];
                    m_h[0] = zb;
                end
            end
            if (m_cnt < 241) m_cnt++;
        end
    endfunction

    task automatic check(bit cond, string tag, int act, int expv);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic compare_now(string tag);
        bit ev = m_run && (m_cnt == 241);
        bit ez = ev && m_z();
        check(ks_valid === ev, {tag, " R8 valid"}, int'(ks_valid), int'(ev));
        check(ks === ez, {tag, " R6 stream bit"}, int'(ks), int'(ez));
    endtask

    // one clock: compare at negedge, drive inputs, advance model to match next edge
    task automatic cyc(bit i_init, bit i_start, string tag);
        @(negedge clk);
        compare_now(tag);
        init  = i_init;
        start = i_start;
        m_step(i_init, i_start);
    endtask

    task automatic run(int n, string tag, output int first_valid);
        first_valid = -1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (ks_valid && first_valid < 0) first_valid = k;
            compare_now(tag);
            init = 1'b0; start = 1'b0;
            m_step(1'b0, 1'b0);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int fv;
        m_clear();
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ks === 1'b0 && ks_valid === 1'b0, "R1 reset outputs", int'({ks, ks_valid}), 0);
        rst_n = 1'b1;
        repeat (4) cyc(1'b0, 1'b0, "R1 idle");

        // single key bit: fill, staggered feedback, taps (R2 R3 R4 R5)
        key = 128'h1; addr = '0; tick = '0;
        cyc(1'b0, 1'b1, "R2");
        run(300, "R2/R3/R4/R5", fv);
        check(fv == 241, "R8 valid latency", fv, 241);

        // mixed pattern through reload (R7)
        key  = 128'h3D33_000E_C000_00C0_0000_0000_01F8_0001;
        addr = 48'hAAAA_AAAA_AAAA;
        tick = 26'h2A5_5A3;
        cyc(1'b0, 1'b1, "R7");
        run(270, "R5/R6/R7", fv);
        check(fv == 241, "R8 valid latency pattern", fv, 241);

        // restart mid-run (R10)
        key  = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        addr = 48'h5555_5555_5555;
        tick = 26'h1;
        cyc(1'b0, 1'b1, "R10");
        run(100, "R10 first", fv);
        key  = 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555;
        cyc(1'b0, 1'b1, "R10");
        run(260, "R10 restarted", fv);
        check(fv == 241, "R10 restart latency", fv, 241);

        // init during stream (R9)
        cyc(1'b1, 1'b0, "R9");
        @(negedge clk);
        check(ks_valid === 1'b0 && ks === 1'b0, "R9 init clears", int'({ks, ks_valid}), 0);
        compare_now("R9 after init");
        init = 1'b0;
        m_step(1'b0, 1'b0);
        run(20, "R9 idle", fv);

        // init and start together: init wins (R9)
        key = '1; addr = '1; tick = '1;
        cyc(1'b1, 1'b1, "R9 priority");
        run(250, "R9 priority", fv);
        check(fv == -1, "R9 init beats start", fv, -1);

        // all ones inputs (R2 R4 R6)
        cyc(1'b0, 1'b1, "R4");
        run(280, "R2/R4/R6 ones", fv);
        check(fv == 241, "R8 valid latency ones", fv, 241);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule